// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one start pulse into the stream of column addresses that a synchronous DRAM burst walks through. A memory controller presents a starting column, a length code, an ordering select and a read/write indication together with a one-cycle start pulse. Starting in the next cycle, the block emits one column address per clock and marks the final beat. It stops early when a terminate input arrives.

Fixed bursts of two, four or eight beats stay inside the naturally aligned group of columns that holds the starting column. The low bits wrap, and the upper bits never change. The ordering inside the group is either a count upward or an exclusive-OR of the start offset with the beat number. A full-page burst counts upward through the whole column space, wraps from the top column to column zero, and only ends on a terminate.

A new start may arrive on any cycle, including the final beat of the previous burst, so bursts can run back to back with no idle cycle.

Top module: `bcol_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `beat_vld_o` and `beat_last_o` are low and `beat_col_o` is zero.
- R2: A start sampled at a clock edge makes `beat_vld_o` high with `beat_col_o` equal to the sampled `start_col_i` after that edge (beat 0). Each later edge advances one beat until the burst ends.
- R3: `len_code_i` encodes the length as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The unused codes 4, 5 and 6 behave as length 1.
- R4: In sequential order with length L in {2,4,8}, beat i has low log2(L) bits equal to (start + i) mod L. All higher column bits keep the start's value.
- R5: In interleaved order (`ilv_i`=1) with length L in {2,4,8}, beat i has low log2(L) bits equal to start XOR i. All higher column bits keep the start's value.
- R6: A full-page burst always uses sequential order, whatever `ilv_i` is. Its beat i is (start + i) mod 2^COL_W, and it keeps running until terminated.
- R7: `beat_last_o` is high only together with `beat_vld_o`. On a fixed burst it rises on beat L-1. With no new start at that edge, `beat_vld_o` is low in the cycle after the last beat.
- R8: If `term_i` is sampled high while a burst is running and its current beat is not the last, the beat presented after that edge is the final one, with `beat_last_o` high. This holds for fixed and full-page bursts alike.
- R9: A start takes priority over the running burst and over `term_i` at the same edge. The new burst's beat 0 follows at once, including when the start is sampled on the old burst's last beat.
- R10: When `is_wr_i` and `wr_single_i` are both high at the start, the burst has length 1 whatever the code. For a read, `wr_single_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst at this edge |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| is_wr_i | input | 1 | The burst is a write |
| wr_single_i | input | 1 | Writes are single-beat |
| term_i | input | 1 | End the running burst after the next beat |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is being presented |
| beat_last_o | output | 1 | The current beat is the final one |

## Verification
Two functions can fall in the same cycle: a start together with a terminate, and a start on the final beat of the running burst. The bench provokes both. It raises `start_i` and `term_i` together in the middle of an eight-beat burst and expects the new burst to run its full length. It also starts a new burst on the last beat of a two-beat burst and expects beat 0 of the new burst in the very next cycle, with no gap in `beat_vld_o`. A behavioural model that computes each beat arithmetically judges every cycle, and tagged spot checks confirm the wrap points.

// File: rtl/bcol_pkg.sv
package bcol_pkg;
    localparam int LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'd0;
    localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'd1;
    localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'd2;
    localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;
    localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'd7;
    // largest fixed group is 2**MAX_GRP_LOG columns
    localparam int MAX_GRP_LOG = 3;
endpackage

// File: rtl/bcol_len_decode.sv
module bcol_len_decode
    import bcol_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  force_one_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o
);
    localparam int GRP_LOG_W = $clog2(MAX_GRP_LOG + 1);

    logic [GRP_LOG_W-1:0] grp_log;

    always_comb begin
        full_o  = 1'b0;
        grp_log = '0;
        if (!force_one_i) begin
            unique case (code_i)
                LEN_TWO:   grp_log = GRP_LOG_W'(1);
                LEN_FOUR:  grp_log = GRP_LOG_W'(2);
                LEN_EIGHT: grp_log = GRP_LOG_W'(3);
                LEN_PAGE:  full_o  = 1'b1;
                default:   grp_log = '0;
            endcase
        end
    end

    // one mask bit per column bit, set below the group size
    for (genvar b = 0; b < COL_W; b++) begin : g_mask
        assign mask_o[b] = full_o || (b < int'(grp_log));
    end
endmodule

// File: rtl/bcol_beat_calc.sv
module bcol_beat_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] off_start;
    logic [COL_W-1:0] off_seq;
    logic [COL_W-1:0] off_ilv;
    logic [COL_W-1:0] off_sel;

    always_comb begin
        off_start = base_i & mask_i;
        off_seq   = off_start + cnt_i;
        off_ilv   = off_start ^ cnt_i;
        off_sel   = ilv_i ? off_ilv : off_seq;
        col_o     = (base_i & ~mask_i) | (off_sel & mask_i);
    end
endmodule

// File: rtl/bcol_addr_gen.sv
module bcol_addr_gen
    import bcol_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  is_wr_i,
    input  logic                  wr_single_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      beat_col_o,
    output logic                  beat_vld_o,
    output logic                  beat_last_o
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] cnt;
        logic             ilv;
        logic             full;
        logic             valid;
        logic             last;
    } gen_st_t;

    gen_st_t st_q, st_d;

    logic [COL_W-1:0] new_mask;
    logic             new_full;
    logic [COL_W-1:0] calc_base, calc_mask, calc_cnt, calc_col;
    logic             calc_ilv;
    logic [COL_W-1:0] cnt_nxt;

    bcol_len_decode #(.COL_W(COL_W)) len_dec_i (
        .code_i      (len_code_i),
        .force_one_i (is_wr_i & wr_single_i),
        .mask_o      (new_mask),
        .full_o      (new_full)
    );

    always_comb begin
        cnt_nxt = st_q.cnt + COL_W'(1);
        if (start_i) begin
            calc_base = start_col_i;
            calc_mask = new_mask;
            calc_cnt  = '0;
            calc_ilv  = ilv_i & ~new_full;
        end else begin
            calc_base = st_q.base;
            calc_mask = st_q.mask;
            calc_cnt  = cnt_nxt;
            calc_ilv  = st_q.ilv;
        end
    end

    bcol_beat_calc #(.COL_W(COL_W)) beat_i (
        .base_i (calc_base),
        .mask_i (calc_mask),
        .cnt_i  (calc_cnt),
        .ilv_i  (calc_ilv),
        .col_o  (calc_col)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.base  = start_col_i;
            st_d.mask  = new_mask;
            st_d.full  = new_full;
            st_d.ilv   = calc_ilv;
            st_d.cnt   = '0;
            st_d.col   = calc_col;
            st_d.valid = 1'b1;
            st_d.last  = !new_full && (new_mask == '0);
        end else if (st_q.valid && !st_q.last) begin
            st_d.cnt   = cnt_nxt;
            st_d.col   = calc_col;
            st_d.valid = 1'b1;
            st_d.last  = term_i || (!st_q.full && (cnt_nxt == st_q.mask));
        end else begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_col_o  = st_q.col;
    assign beat_vld_o  = st_q.valid;
    assign beat_last_o = st_q.last;

    // R7
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_vld_o);

    // R7
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last_o && !start_i) |=> !beat_vld_o);

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && beat_col_o == $past(start_col_i)));

    // R8
    term_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !beat_last_o && term_i && !start_i) |=> beat_last_o);

    // R4
    group_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !beat_last_o && !start_i && !st_q.full)
        |=> ((beat_col_o & ~st_q.mask) == $past(beat_col_o & ~st_q.mask)));

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !beat_last_o && !start_i && st_q.full)
        |=> (beat_col_o == $past(beat_col_o) + COL_W'(1)));
endmodule

// File: tb/bcol_addr_gen_tb_top.sv
module bcol_addr_gen_tb_top;
    localparam int COL_W = 10;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             is_wr_i = 1'b0;
    logic             wr_single_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] beat_col_o;
    logic             beat_vld_o;
    logic             beat_last_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bcol_addr_gen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .is_wr_i(is_wr_i),
        .wr_single_i(wr_single_i), .term_i(term_i), .beat_col_o(beat_col_o),
        .beat_vld_o(beat_vld_o), .beat_last_o(beat_last_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference
    int m_valid = 0, m_last = 0, m_col = 0, m_s = 0, m_i = 0, m_len = 1, m_ilv = 0;

    function automatic int ref_col(int s, int i, int len, int ilv);
        int base, off;
        if (len == 0) return (s + i) % PAGE;
        base = s - (s % len);
        off  = ilv ? ((s % len) ^ i) : ((s % len + i) % len);
        return base + off;
    endfunction

    function automatic int code_len(int code, bit single);
        if (single) return 1;
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            cycles++;
            if (start_i) begin
                m_s     = int'(start_col_i);
                m_len   = code_len(int'(len_code_i), is_wr_i && wr_single_i);
                m_ilv   = (m_len == 0) ? 0 : int'(ilv_i);
                m_i     = 0;
                m_valid = 1;
                m_last  = (m_len == 1);
                m_col   = m_s;
            end else if (m_valid == 1 && m_last == 0) begin
                m_i++;
                m_col  = ref_col(m_s, m_i, m_len, m_ilv);
                m_last = (term_i || (m_len != 0 && m_i == m_len - 1)) ? 1 : 0;
            end else begin
                m_valid = 0;
                m_last  = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(beat_vld_o) == m_valid, "R2 valid", int'(beat_vld_o), m_valid);
            chk(int'(beat_last_o) == m_last, "R7 last", int'(beat_last_o), m_last);
            if (m_valid == 1)
                chk(int'(beat_col_o) == m_col,
                    (m_len == 0) ? "R6 column" : (m_ilv ? "R5 column" : "R4 column"),
                    int'(beat_col_o), m_col);
        end
    end

    // start applied at a falling edge; returns at the falling edge showing beat 0
    task automatic go(input int col, input int code, input bit ilv, input bit wr, input bit sw);
        start_i     = 1'b1;
        start_col_i = COL_W'(col);
        len_code_i  = 3'(code);
        ilv_i       = ilv;
        is_wr_i     = wr;
        wr_single_i = sw;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk(beat_vld_o == 1'b0 && beat_last_o == 1'b0, "R1 reset flags",
            int'({beat_vld_o, beat_last_o}), 0);
        chk(beat_col_o == '0, "R1 reset col", int'(beat_col_o), 0);
        step(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o == 1'b0, "R1 after reset", int'(beat_vld_o), 0);

        // sequential length 8 from 45: 45 46 47 40 ...
        go(45, 3, 0, 0, 0);
        chk(int'(beat_col_o) == 45, "R2 beat0", int'(beat_col_o), 45);
        step(3);
        chk(int'(beat_col_o) == 40, "R4 wrap", int'(beat_col_o), 40);
        step(4);
        chk(beat_last_o == 1'b1, "R7 beat7 last", int'(beat_last_o), 1);
        step(1);
        chk(beat_vld_o == 1'b0, "R7 idle", int'(beat_vld_o), 0);

        // interleaved length 8 from 45: offsets 5 4 7 6 1 0 3 2
        go(45, 3, 1, 0, 0);
        step(2);
        chk(int'(beat_col_o) == 47, "R5 beat2", int'(beat_col_o), 47);
        step(5);
        chk(int'(beat_col_o) == 42, "R5 beat7", int'(beat_col_o), 42);
        step(2);

        // interleaved length 4 from 1022: 1022 1023 1020 1021
        go(1022, 2, 1, 0, 0);
        step(2);
        chk(int'(beat_col_o) == 1020, "R5 len4 beat2", int'(beat_col_o), 1020);
        step(2);

        // sequential length 2 from 7: 7 6
        go(7, 1, 0, 0, 0);
        step(1);
        chk(int'(beat_col_o) == 6, "R4 len2 beat1", int'(beat_col_o), 6);
        step(2);

        // full page from 1022 with ilv set (ignored): 1022 1023 0 1 ...
        go(1022, 7, 1, 0, 0);
        step(2);
        chk(int'(beat_col_o) == 0, "R6 page wrap", int'(beat_col_o), 0);
        step(20);
        chk(beat_vld_o == 1'b1 && beat_last_o == 1'b0, "R6 runs on",
            int'({beat_vld_o, beat_last_o}), 2);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk(beat_last_o == 1'b1, "R8 page term", int'(beat_last_o), 1);
        step(1);
        chk(beat_vld_o == 1'b0, "R8 after term", int'(beat_vld_o), 0);

        // terminate a fixed burst at beat 1
        go(16, 3, 0, 0, 0);
        step(1);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk(beat_last_o == 1'b1 && int'(beat_col_o) == 18, "R8 fixed term",
            int'(beat_col_o), 18);
        step(2);

        // reserved code 5 acts as length 1
        go(300, 5, 0, 0, 0);
        chk(beat_last_o == 1'b1, "R3 reserved len1", int'(beat_last_o), 1);
        step(1);
        chk(beat_vld_o == 1'b0, "R3 reserved idle", int'(beat_vld_o), 0);

        // single-location write vs. read
        go(200, 3, 0, 1, 1);
        chk(beat_last_o == 1'b1, "R10 write single", int'(beat_last_o), 1);
        step(1);
        go(200, 3, 0, 0, 1);
        chk(beat_last_o == 1'b0, "R10 read unaffected", int'(beat_last_o), 0);
        step(7);
        chk(beat_last_o == 1'b1, "R10 read len8", int'(beat_last_o), 1);
        step(2);

        // start together with terminate mid-burst: start wins
        go(64, 3, 0, 0, 0);
        step(2);
        term_i = 1'b1;
        go(100, 2, 0, 0, 0);
        term_i = 1'b0;
        chk(int'(beat_col_o) == 100 && beat_last_o == 1'b0, "R9 start over term",
            int'(beat_col_o), 100);
        step(3);
        chk(beat_last_o == 1'b1 && int'(beat_col_o) == 103, "R9 new burst full",
            int'(beat_col_o), 103);

        // start on the final beat: no gap
        go(10, 1, 0, 0, 0);
        step(1);
        go(20, 0, 0, 0, 0);
        chk(beat_vld_o == 1'b1 && int'(beat_col_o) == 20, "R9 back to back",
            int'(beat_col_o), 20);
        step(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule